// File: doc/BRIEF.md
# Addressable Latch Bank with Demultiplexer Mode

This block is a bank of single-bit storage cells that share one data input and are picked by a binary select. Two active-low controls, a clear and an enable, choose between four modes. In the first, one addressed bit is written. In the second, the whole bank holds. In the third, the block acts as a one-of-N demultiplexer. In the fourth, it clears. All cells appear in parallel on the output, so a sequence of writes to successive addresses turns a serial bit stream into a parallel word.

The block is a clocked stand-in for a level-sensitive part. The output is the combinational next state: it responds to the controls, select and data in the same cycle, the way a transparent latch would. The storage register samples that same value on every rising clock edge. A clear or a demultiplexer pattern therefore reaches the output at once, with no wait for a clock edge. Banks wider than eight bits come from the select-width parameter.

Top module: `addr_latch_bank`

## Requirements
- R1: The mode comes from {clr_n, en_n}. 2'b10 is write mode, 2'b11 is hold mode, 2'b00 is demultiplexer mode and 2'b01 is clear mode.
- R2: In write mode, output bit sel shows din in the same cycle, and the storage keeps that value from the next rising clock edge.
- R3: In write mode, every bit other than bit sel keeps its stored value, both on q and in storage.
- R4: In hold mode, q and the storage stay unchanged whatever din and sel do.
- R5: In demultiplexer mode, q[sel] equals din and every other bit of q is 0.
- R6: When demultiplexer mode is left for hold mode, the stored word is the last pattern driven in demultiplexer mode.
- R7: In clear mode, q is all zero in the same cycle whatever sel and din are, and the storage is zero after the next rising edge.
- R8: sel is an unsigned binary index with bit 0 as least significant: 0 addresses q[0] and all-ones addresses the top bit.
- R9: q is 2**SEL_W bits wide, which is 8 with the default SEL_W of 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the storage |
| clr_n | input | 1 | Active-low clear control, one half of the mode |
| en_n | input | 1 | Active-low enable control, the other half of the mode |
| din | input | 1 | Data bit written or routed to the addressed output |
| sel | input | SEL_W | Binary address of the target bit |
| q | output | 2**SEL_W | Parallel outputs, equal to the next stored state |

## Verification
The checks on stored state assume that the bank has passed through clear mode at least once. Until then the storage is undefined, because the block has no separate reset. The bench starts in clear mode and keeps every control and select change on the falling clock edge, so each rising edge samples stable inputs. This mirrors the rule that the address must settle before the enable goes active. A select change in write mode is therefore always a deliberate write to the new address, and never a stray write during an address transition.

// File: rtl/latch_bank_pkg.sv
package latch_bank_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } bank_mode_e;

  // Mode from the two active-low controls (R1).
  function automatic bank_mode_e decode_mode(input logic clr_n, input logic en_n);
    bank_mode_e m;
    case ({clr_n, en_n})
      2'b10:   m = MODE_WRITE;
      2'b11:   m = MODE_HOLD;
      2'b00:   m = MODE_DEMUX;
      default: m = MODE_CLEAR;
    endcase
    return m;
  endfunction

  // Value of one cell for the next state, given its address match.
  function automatic logic cell_next(input logic wr, input logic hold, input logic dmx,
                                     input logic hit, input logic d, input logic cur);
    logic v;
    if (wr)        v = hit ? d : cur;
    else if (hold) v = cur;
    else if (dmx)  v = hit & d;
    else           v = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/latch_mode_decode.sv
module latch_mode_decode
  import latch_bank_pkg::*;
(
  input  logic clr_n,
  input  logic en_n,
  output logic is_write,
  output logic is_hold,
  output logic is_demux,
  output logic is_clear
);
  bank_mode_e mode;

  always_comb begin
    mode     = decode_mode(clr_n, en_n);
    is_write = (mode == MODE_WRITE);
    is_hold  = (mode == MODE_HOLD);
    is_demux = (mode == MODE_DEMUX);
    is_clear = (mode == MODE_CLEAR);
  end
endmodule

// File: rtl/latch_sel_decode.sv
module latch_sel_decode #(
  parameter int SEL_W   = 3,
  localparam int NUM_OUT = 1 << SEL_W
) (
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_OUT-1:0] hot
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_hit
    assign hot[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/latch_next_state.sv
module latch_next_state
  import latch_bank_pkg::*;
#(
  parameter int NUM_OUT = 8
) (
  input  logic               is_write,
  input  logic               is_hold,
  input  logic               is_demux,
  input  logic [NUM_OUT-1:0] hot,
  input  logic               din,
  input  logic [NUM_OUT-1:0] state,
  output logic [NUM_OUT-1:0] nxt
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
    assign nxt[i] = cell_next(is_write, is_hold, is_demux, hot[i], din, state[i]);
  end
endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank #(
  parameter int SEL_W   = 3,
  localparam int NUM_OUT = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               en_n,
  input  logic               din,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_OUT-1:0] q
);
  logic               is_write;
  logic               is_hold;
  logic               is_demux;
  logic               is_clear;
  logic [NUM_OUT-1:0] sel_hot;
  logic [NUM_OUT-1:0] state;
  logic [NUM_OUT-1:0] nxt;

  latch_mode_decode u_mode (
    .clr_n    (clr_n),
    .en_n     (en_n),
    .is_write (is_write),
    .is_hold  (is_hold),
    .is_demux (is_demux),
    .is_clear (is_clear)
  );

  latch_sel_decode #(.SEL_W(SEL_W)) u_sel (
    .sel (sel),
    .hot (sel_hot)
  );

  latch_next_state #(.NUM_OUT(NUM_OUT)) u_next (
    .is_write (is_write),
    .is_hold  (is_hold),
    .is_demux (is_demux),
    .hot      (sel_hot),
    .din      (din),
    .state    (state),
    .nxt      (nxt)
  );

  // Storage samples the shown value every edge; clear mode yields zero.
  always_ff @(posedge clk) begin
    state <= nxt;
  end

  assign q = nxt;
endmodule

// File: rtl/addr_latch_bank_chk.sv
module addr_latch_bank_chk #(
  parameter int SEL_W   = 3,
  localparam int NUM_OUT = 1 << SEL_W
) (
  input logic               clk,
  input logic               din,
  input logic [SEL_W-1:0]   sel,
  input logic [NUM_OUT-1:0] q,
  input logic               is_write,
  input logic               is_hold,
  input logic               is_demux,
  input logic               is_clear,
  input logic [NUM_OUT-1:0] state
);
  logic primed = 1'b0;

  always_ff @(posedge clk) begin
    if (is_clear) primed <= 1'b1;
  end

  assert_write_scope_R3: assert property (@(posedge clk) disable iff (!primed)
    is_write |=> (((state ^ $past(state)) & ~(NUM_OUT'(1) << $past(sel))) == '0));

  assert_write_value_R2: assert property (@(posedge clk) disable iff (!primed)
    is_write |=> (state[$past(sel)] == $past(din)));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!primed)
    is_hold |=> $stable(state));

  assert_demux_shape_R5: assert property (@(posedge clk) disable iff (!primed)
    is_demux |-> (($countones(q) <= 1) && (q[sel] == din)));

  assert_demux_keep_R6: assert property (@(posedge clk) disable iff (!primed)
    is_demux |=> (state == $past(q)));

  assert_clear_out_R7: assert property (@(posedge clk) disable iff (!primed)
    is_clear |-> (q == '0));

  assert_clear_store_R7: assert property (@(posedge clk) disable iff (!primed)
    is_clear |=> (state == '0));
endmodule

bind addr_latch_bank addr_latch_bank_chk #(.SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .din      (din),
  .sel      (sel),
  .q        (q),
  .is_write (is_write),
  .is_hold  (is_hold),
  .is_demux (is_demux),
  .is_clear (is_clear),
  .state    (state)
);

// File: tb/addr_latch_bank_test.sv
module addr_latch_bank_test;
  localparam int SW = 3;
  localparam int NO = 1 << SW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          clr_n = 1'b0;
  logic          en_n  = 1'b1;
  logic          din   = 1'b0;
  logic [SW-1:0] sel   = '0;
  wire  [NO-1:0] q;

  typedef struct {
    logic [NO-1:0] exp;
    string         tag;
  } item_t;

  item_t         sb[$];
  int            checks = 0;
  int            fails  = 0;
  logic [NO-1:0] model  = '0;

  addr_latch_bank #(.SEL_W(SW)) uut (
    .clk   (clk),
    .clr_n (clr_n),
    .en_n  (en_n),
    .din   (din),
    .sel   (sel),
    .q     (q)
  );

  // Driver: apply inputs on the falling edge and queue the expected output.
  task automatic step(input logic c, input logic e, input logic d,
                      input logic [SW-1:0] s, input string tag);
    logic [NO-1:0] one;
    item_t         it;
    @(negedge clk);
    clr_n = c; en_n = e; din = d; sel = s;
    one = NO'(1) << s;
    case ({c, e})
      2'b10:   it.exp = d ? (model | one) : (model & ~one);
      2'b11:   it.exp = model;
      2'b00:   it.exp = d ? one : '0;
      default: it.exp = '0;
    endcase
    it.tag = tag;
    sb.push_back(it);
    model = it.exp;
  endtask

  // Monitor: compare between edges, once the inputs have settled.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (q !== it.exp) begin
          fails++;
          $display("FAIL %s: q=%b expected %b", it.tag, q, it.exp);
        end
      end
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    checks++;
    if ($bits(q) != 8) begin
      fails++;
      $display("FAIL R9: width=%0d expected 8", $bits(q));
    end
    step(1'b0, 1'b1, 1'b1, 3'd5, "R7 clear ignores din=1 sel=5");
    step(1'b0, 1'b1, 1'b0, 3'd0, "R7 clear ignores din=0 sel=0");
    step(1'b1, 1'b0, 1'b1, 3'd0, "R2 R8 write bit0");
    step(1'b1, 1'b0, 1'b1, 3'd7, "R8 write top bit");
    step(1'b1, 1'b0, 1'b1, 3'd3, "R3 write bit3 keeps others");
    step(1'b1, 1'b0, 1'b0, 3'd0, "R3 write 0 to bit0 keeps others");
    step(1'b1, 1'b1, 1'b1, 3'd2, "R4 hold ignores din=1 sel=2");
    step(1'b1, 1'b1, 1'b0, 3'd3, "R4 hold ignores din=0 sel=3");
    step(1'b0, 1'b0, 1'b1, 3'd5, "R5 R1 demux sel5 din1");
    step(1'b0, 1'b0, 1'b0, 3'd2, "R5 demux din0 all low");
    step(1'b0, 1'b0, 1'b1, 3'd6, "R5 demux sel6 din1");
    step(1'b1, 1'b1, 1'b0, 3'd1, "R6 hold keeps last demux pattern");
    step(1'b1, 1'b1, 1'b1, 3'd7, "R6 pattern still held");
    step(1'b1, 1'b0, 1'b1, 3'd1, "R2 R1 write on demux leftover");
    step(1'b0, 1'b1, 1'b1, 3'd1, "R7 R1 clear with live data");
    step(1'b1, 1'b1, 1'b1, 3'd4, "R7 storage zero after clear");
    for (int i = 0; i < NO; i++) begin
      step(1'b1, 1'b0, 1'b1, SW'(i), "R3 serial fill one bit each");
    end
    step(1'b1, 1'b1, 1'b0, 3'd0, "R4 hold full word");
    for (int i = NO - 1; i >= 0; i--) begin
      step(1'b1, 1'b0, i[0], SW'(i), "R2 R8 serial alternating fill");
    end
    step(1'b1, 1'b1, 1'b0, 3'd6, "R4 hold alternating word");
    repeat (3) @(negedge clk);
    #3;
    finish_run();
  end
endmodule